// File: doc/BRIEF.md
# Conditional Control-Transfer Sequencer

This block carries out the control-transfer group of an 8-bit processor with a 16-bit program counter and a stack in memory that grows downward. The group covers jumps, calls, returns, restarts and the load of the PC from the HL pair. A host presents an opcode together with its two address bytes, the flags, the current PC, SP and HL, and then pulses `start`. The block decodes the opcode and tests its three-bit condition against the flags. It then issues the stack writes or reads the instruction needs. When it finishes, it pulses `done` and presents the new PC, the new SP and the number of clock states the instruction takes on the processor.

`pc_in` is the address of the opcode byte. Instructions with address bytes are three bytes long. Returns, restarts and the HL load are one byte long. The stack memory is synchronous: read data returns one cycle after the request. Instruction fetch and bus timing are handled elsewhere.

Top module: `ctl_xfer_seq`

## Requirements
- R1: The condition field is opcode bits 5..3 and is true when the selected flag equals bit 3. Bits 5..4 pick the flag: 00 zero, 01 carry, 10 parity (1 = even), 11 sign. So 000 not-zero, 001 zero, 010 no-carry, 011 carry, 100 parity-odd, 101 parity-even, 110 positive, 111 minus.
- R2: Opcode 0xC3 and opcodes 11ccc010 jump to {addr_hi,addr_lo} when taken. Otherwise the PC becomes pc_in+3. SP is unchanged and the state count is 10 in both cases.
- R3: Opcode 0xCD and opcodes 11ccc100 push pc_in+3 when taken: the high byte goes to SP-1, then the low byte to SP-2. SP becomes SP-2, the PC becomes {addr_hi,addr_lo}, and the state count is 17. An untaken conditional call gives PC pc_in+3, SP unchanged and 11 states.
- R4: Opcode 0xC9 and opcodes 11ccc000 pop when taken: the low byte is read from SP, then the high byte from SP+1. The PC becomes {high,low} and SP becomes SP+2. The state count is 10 for 0xC9 and 11 for a taken conditional return. An untaken conditional return gives PC pc_in+1, SP unchanged and 5 states.
- R5: Opcodes 11aaa111 push pc_in+1 in the same way as a call, set the PC to aaa×8 and report 11 states.
- R6: Opcode 0xE9 sets the PC to hl_in, leaves SP unchanged and reports 5 states.
- R7: Any other opcode leaves PC and SP equal to their inputs, reports 0 states and makes no stack access.
- R8: `done` is a one-cycle pulse. It rises 1 cycle after `start` with no stack access, 3 cycles after `start` with a push and 4 cycles after `start` with a pop. `busy` is high between these two points and low whenever `done` is high.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: A stack read and a stack write are never requested in the same cycle. The block takes read data in the cycle after a read request.
- R11: After reset, `busy`, `done`, `stk_wr` and `stk_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction with the presented operands |
| opcode | input | 8 | Instruction opcode |
| addr_lo | input | DATA_W | First address byte (low) |
| addr_hi | input | DATA_W | Second address byte (high) |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag, 1 = even |
| flag_s | input | 1 | Sign flag |
| pc_in | input | ADDR_W | Address of the opcode byte |
| sp_in | input | ADDR_W | Current stack pointer |
| hl_in | input | ADDR_W | HL register pair |
| rd_data | input | DATA_W | Stack read data, one cycle after the request |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | Instruction finished; results valid |
| pc_out | output | ADDR_W | New program counter |
| sp_out | output | ADDR_W | New stack pointer |
| states | output | CNT_W | Clock-state count of the instruction |
| stk_wr | output | 1 | Stack write request |
| stk_rd | output | 1 | Stack read request |
| stk_addr | output | ADDR_W | Stack access address |
| stk_wdata | output | DATA_W | Stack write data |

## Verification
Every result is due a fixed number of cycles after the `start` edge. The delay is one cycle when there is no stack access and three cycles for a push: two writes, then `done`. A pop takes four cycles: two reads, one cycle for the last data to return, then `done`. The bench raises `start` on a falling edge and counts falling edges until `done` is seen. It compares that count with the expected latency and samples PC, SP, the state count and the pushed stack bytes at that same falling edge, so each value is read after the edge that registered it. A `start` during a sequence, and the absence of a second `done` afterwards, are checked at the same falling-edge points.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [3:0] {
    K_JMP, K_JCC, K_CALL, K_CCC, K_RET, K_RCC, K_RST, K_PCHL, K_OTHER
  } xfer_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_HI, S_PUSH_LO, S_POP_LO, S_POP_HI, S_POP_WAIT
  } seq_state_t;

  localparam int ST_JUMP      = 10;
  localparam int ST_CALL      = 17;
  localparam int ST_CALL_SKIP = 11;
  localparam int ST_RET       = 10;
  localparam int ST_RET_TAKEN = 11;
  localparam int ST_RET_SKIP  = 5;
  localparam int ST_RESTART   = 11;
  localparam int ST_PCHL      = 5;
endpackage

// File: rtl/ctx_cond.sv
module ctx_cond (
  input  logic [2:0] ccc,
  input  logic       flag_z,
  input  logic       flag_cy,
  input  logic       flag_p,
  input  logic       flag_s,
  output logic       cond_ok
);
  logic [3:0] flag_vec;
  assign flag_vec = {flag_s, flag_p, flag_cy, flag_z};
  // bits 5..4 select the flag, bit 3 gives the polarity that counts as true
  assign cond_ok = (flag_vec[ccc[2:1]] == ccc[0]);
endmodule

// File: rtl/ctx_decode.sv
module ctx_decode
  import ctx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [7:0]       opcode,
  input  logic             cond_ok,
  output xfer_kind_t       kind,
  output logic             taken,
  output logic             do_push,
  output logic             do_pop,
  output logic [CNT_W-1:0] st_count
);
  always_comb begin
    kind = K_OTHER;
    if (opcode == 8'hC3)      kind = K_JMP;
    else if (opcode == 8'hCD) kind = K_CALL;
    else if (opcode == 8'hC9) kind = K_RET;
    else if (opcode == 8'hE9) kind = K_PCHL;
    else if (opcode[7:6] == 2'b11) begin
      case (opcode[2:0])
        3'b010:  kind = K_JCC;
        3'b100:  kind = K_CCC;
        3'b000:  kind = K_RCC;
        3'b111:  kind = K_RST;
        default: kind = K_OTHER;
      endcase
    end
  end

  always_comb begin
    taken    = 1'b0;
    st_count = '0;
    case (kind)
      K_JMP:  begin taken = 1'b1;    st_count = CNT_W'(ST_JUMP); end
      K_JCC:  begin taken = cond_ok; st_count = CNT_W'(ST_JUMP); end
      K_CALL: begin taken = 1'b1;    st_count = CNT_W'(ST_CALL); end
      K_CCC:  begin
        taken    = cond_ok;
        st_count = cond_ok ? CNT_W'(ST_CALL) : CNT_W'(ST_CALL_SKIP);
      end
      K_RET:  begin taken = 1'b1;    st_count = CNT_W'(ST_RET); end
      K_RCC:  begin
        taken    = cond_ok;
        st_count = cond_ok ? CNT_W'(ST_RET_TAKEN) : CNT_W'(ST_RET_SKIP);
      end
      K_RST:  begin taken = 1'b1;    st_count = CNT_W'(ST_RESTART); end
      K_PCHL: begin taken = 1'b1;    st_count = CNT_W'(ST_PCHL); end
      default: begin taken = 1'b0;   st_count = '0; end
    endcase
  end

  assign do_push = taken && (kind == K_CALL || kind == K_CCC || kind == K_RST);
  assign do_pop  = taken && (kind == K_RET || kind == K_RCC);
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
  import ctx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] addr_hi,
  input  logic              flag_z,
  input  logic              flag_cy,
  input  logic              flag_p,
  input  logic              flag_s,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [CNT_W-1:0]  states,
  output logic              stk_wr,
  output logic              stk_rd,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_wdata
);
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] THREE = ADDR_W'(3);

  logic             cond_ok, taken, do_push, do_pop;
  xfer_kind_t       kind;
  logic [CNT_W-1:0] st_count;

  ctx_cond u_cond (
    .ccc(opcode[5:3]), .flag_z(flag_z), .flag_cy(flag_cy),
    .flag_p(flag_p), .flag_s(flag_s), .cond_ok(cond_ok)
  );

  ctx_decode #(.CNT_W(CNT_W)) u_dec (
    .opcode(opcode), .cond_ok(cond_ok), .kind(kind), .taken(taken),
    .do_push(do_push), .do_pop(do_pop), .st_count(st_count)
  );

  logic [ADDR_W-1:0] seq1, seq3, abs_tgt, ret_addr, push_tgt, flat_pc;
  assign seq1     = pc_in + ONE;
  assign seq3     = pc_in + THREE;
  assign abs_tgt  = {addr_hi, addr_lo};
  assign ret_addr = (kind == K_RST) ? seq1 : seq3;
  assign push_tgt = (kind == K_RST) ? ADDR_W'({opcode[5:3], 3'b000}) : abs_tgt;

  // PC for instructions that finish without a stack access
  always_comb begin
    case (kind)
      K_JMP, K_JCC:  flat_pc = taken ? abs_tgt : seq3;
      K_CALL, K_CCC: flat_pc = seq3;
      K_RET, K_RCC:  flat_pc = seq1;
      K_RST:         flat_pc = seq1;
      K_PCHL:        flat_pc = hl_in;
      default:       flat_pc = pc_in;
    endcase
  end

  seq_state_t        st;
  logic [DATA_W-1:0] ret_lo_q, pop_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      stk_wr    <= 1'b0;
      stk_rd    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      pc_out    <= '0;
      sp_out    <= '0;
      states    <= '0;
      ret_lo_q  <= '0;
      pop_lo_q  <= '0;
    end else begin
      done   <= 1'b0;
      stk_wr <= 1'b0;
      stk_rd <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          states <= st_count;
          if (do_push) begin
            st        <= S_PUSH_HI;
            busy      <= 1'b1;
            stk_wr    <= 1'b1;
            stk_addr  <= sp_in - ONE;
            stk_wdata <= ret_addr[ADDR_W-1:DATA_W];
            ret_lo_q  <= ret_addr[DATA_W-1:0];
            pc_out    <= push_tgt;
            sp_out    <= sp_in - TWO;
          end else if (do_pop) begin
            st       <= S_POP_LO;
            busy     <= 1'b1;
            stk_rd   <= 1'b1;
            stk_addr <= sp_in;
            sp_out   <= sp_in + TWO;
          end else begin
            done   <= 1'b1;
            pc_out <= flat_pc;
            sp_out <= sp_in;
          end
        end
        S_PUSH_HI: begin
          stk_wr    <= 1'b1;
          stk_addr  <= stk_addr - ONE;
          stk_wdata <= ret_lo_q;
          st        <= S_PUSH_LO;
        end
        S_PUSH_LO: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        S_POP_LO: begin
          stk_rd   <= 1'b1;
          stk_addr <= stk_addr + ONE;
          st       <= S_POP_HI;
        end
        S_POP_HI: begin
          pop_lo_q <= rd_data;
          st       <= S_POP_WAIT;
        end
        S_POP_WAIT: begin
          pc_out <= {rd_data, pop_lo_q};
          done   <= 1'b1;
          busy   <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
    !(stk_wr && stk_rd));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r3_push_descends: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_wr) |=> (stk_wr && stk_addr == $past(stk_addr) - ONE));
  a_r4_pop_ascends: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_rd) |=> (stk_rd && stk_addr == $past(stk_addr) + ONE));
  a_r3_push_sp: assert property (@(posedge clk) disable iff (rst)
    (done && $past(stk_wr)) |-> sp_out == $past(stk_addr));
  a_r2_state_count_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (states == 0 || states == 5 || states == 10 ||
              states == 11 || states == 17));
endmodule

// File: tb/tb_ctl_xfer_seq.sv
`timescale 1ns/1ps
module tb_ctl_xfer_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00, addr_lo = 8'h34, addr_hi = 8'h56, rd_data;
  logic        flag_z = 0, flag_cy = 0, flag_p = 0, flag_s = 0;
  logic [15:0] pc_in = 16'h1230, sp_in = 16'h0080, hl_in = 16'hBEEF;
  logic        busy, done, stk_wr, stk_rd;
  logic [15:0] pc_out, sp_out, stk_addr;
  logic [4:0]  states;
  logic [7:0]  stk_wdata;

  ctl_xfer_seq dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .flag_z(flag_z), .flag_cy(flag_cy),
    .flag_p(flag_p), .flag_s(flag_s), .pc_in(pc_in), .sp_in(sp_in),
    .hl_in(hl_in), .rd_data(rd_data), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .states(states), .stk_wr(stk_wr),
    .stk_rd(stk_rd), .stk_addr(stk_addr), .stk_wdata(stk_wdata)
  );

  // synchronous stack memory model, read data one cycle after request
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      mem[8'h80] <= 8'h11;
      mem[8'h81] <= 8'h22;
      rd_data    <= 8'h00;
    end else begin
      if (stk_wr) mem[stk_addr[7:0]] <= stk_wdata;
      if (stk_rd) rd_data <= mem[stk_addr[7:0]];
    end
  end

  int checks = 0, errors = 0, both_req = 0, extra_done = 0;
  always @(negedge clk) if (!rst && stk_wr && stk_rd) both_req++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {opcode, flags{s,p,cy,z}, exp_pc, exp_sp, exp_states, exp_latency}
  localparam logic [51:0] VEC [19] = '{
    {8'hC3, 4'b0000, 16'h5634, 16'h0080, 5'd10, 3'd1},
    {8'hC2, 4'b0000, 16'h5634, 16'h0080, 5'd10, 3'd1},
    {8'hCA, 4'b0000, 16'h1233, 16'h0080, 5'd10, 3'd1},
    {8'hDA, 4'b0010, 16'h5634, 16'h0080, 5'd10, 3'd1},
    {8'hE2, 4'b0000, 16'h5634, 16'h0080, 5'd10, 3'd1},
    {8'hEA, 4'b0000, 16'h1233, 16'h0080, 5'd10, 3'd1},
    {8'hF2, 4'b1000, 16'h1233, 16'h0080, 5'd10, 3'd1},
    {8'hFA, 4'b1000, 16'h5634, 16'h0080, 5'd10, 3'd1},
    {8'hCD, 4'b0000, 16'h5634, 16'h007E, 5'd17, 3'd3},
    {8'hC4, 4'b0001, 16'h1233, 16'h0080, 5'd11, 3'd1},
    {8'hDC, 4'b0010, 16'h5634, 16'h007E, 5'd17, 3'd3},
    {8'hC9, 4'b0000, 16'h2211, 16'h0082, 5'd10, 3'd4},
    {8'hC0, 4'b0001, 16'h1231, 16'h0080, 5'd5,  3'd1},
    {8'hF8, 4'b1000, 16'h2211, 16'h0082, 5'd11, 3'd4},
    {8'hFF, 4'b0000, 16'h0038, 16'h007E, 5'd11, 3'd3},
    {8'hCF, 4'b0000, 16'h0008, 16'h007E, 5'd11, 3'd3},
    {8'hE9, 4'b0000, 16'hBEEF, 16'h0080, 5'd5,  3'd1},
    {8'h00, 4'b0000, 16'h1230, 16'h0080, 5'd0,  3'd1},
    {8'h3E, 4'b1111, 16'h1230, 16'h0080, 5'd0,  3'd1}
  };

  function automatic string req_of(input logic [7:0] op);
    if (op == 8'hE9) return "R6";
    if (op[7:6] != 2'b11) return "R7";
    if (op[2:0] == 3'b111) return "R5";
    if (op == 8'hC9 || op[2:0] == 3'b000) return "R4 R1";
    if (op == 8'hCD || op[2:0] == 3'b100) return "R3 R1";
    return "R2 R1";
  endfunction

  task automatic run(input logic [51:0] v);
    logic [15:0] ret;
    int lat;
    string rq;
    rq = req_of(v[51:44]);
    @(negedge clk);
    opcode = v[51:44];
    {flag_s, flag_p, flag_cy, flag_z} = v[43:40];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (v[2:0] > 3'd1) check("R8 busy during sequence", 32'(busy), 32'd1);
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency", 32'(lat), 32'(v[2:0]));
    check("R8 busy low at done", 32'(busy), 32'd0);
    check({rq, " pc"}, 32'(pc_out), 32'(v[39:24]));
    check({rq, " sp"}, 32'(sp_out), 32'(v[23:8]));
    check({rq, " states"}, 32'(states), 32'(v[7:3]));
    if (v[23:8] == 16'h007E) begin
      ret = (v[7:3] == 5'd17) ? 16'h1233 : 16'h1231;
      check({rq, " pushed high byte at SP-1"}, 32'(mem[8'h7F]), 32'(ret[15:8]));
      check({rq, " pushed low byte at SP-2"}, 32'(mem[8'h7E]), 32'(ret[7:0]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 done", 32'(done), 32'd0);
    check("R11 stk_wr", 32'(stk_wr), 32'd0);
    check("R11 stk_rd", 32'(stk_rd), 32'd0);
    rst = 1'b0;

    foreach (VEC[i]) run(VEC[i]);

    // R9: start while busy is ignored
    @(negedge clk);
    opcode = 8'hCD; start = 1'b1;
    @(negedge clk);
    opcode = 8'hE9;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9 done after call", 32'(done), 32'd1);
    check("R9 pc of call kept", 32'(pc_out), 32'h5634);
    check("R9 states of call kept", 32'(states), 32'd17);
    repeat (6) begin
      @(negedge clk);
      if (done) extra_done++;
    end
    check("R9 no second done", 32'(extra_done), 32'd0);

    // R7: ignored opcode issues no stack access
    @(negedge clk);
    opcode = 8'h76; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 no stack write", 32'(stk_wr), 32'd0);
    check("R7 no stack read", 32'(stk_rd), 32'd0);
    check("R7 done", 32'(done), 32'd1);

    check("R10 read and write never together", 32'(both_req), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule